// File: doc/BRIEF.md
# Synchronous Clock Stop Controller

This block gates two groups of derived clocks, a fast processor group and a slower bus group, under two active-low stop requests used for power management. Both requests are captured on the rising edge of a free-running copy of the bus clock. The processor request is then carried into the processor clock domain through a short synchronizer. Each group's gate enable changes only on the falling edge of that group's own source clock. An output therefore comes to rest low and restarts with a full high pulse. It is never cut short.

A group that is not being stopped keeps toggling. A per-group status flag reports whether the group is currently halted. The flag is taken from the same register that drives the gate, so it changes on the same falling edge as the output. Clock synthesis, spread spectrum and output drive strength lie outside this block.

Top module: `clkstop_ctrl`

## Requirements
- R1: `cpu_stop_n` and `pci_stop_n` are active low (0 requests a stop, 1 requests running). They are captured only on the rising edge of `clk_pcif`. A low pulse that starts and ends between two rising edges of `clk_pcif` has no effect on any output or flag.
- R2: A captured processor stop halts every bit of `cpu_clk_o`. `pci_clk_o` keeps toggling.
- R3: A captured bus stop halts every bit of `pci_clk_o`. `cpu_clk_o` keeps toggling.
- R4: A halted group rests at logic 0 on all of its bits. All bits of a group are always equal.
- R5: Every high pulse on an output lasts exactly the high phase of its source clock, including the last pulse before a stop and the first pulse after a restart.
- R6: A captured change of the processor request takes effect at most 2 processor clock periods after the capturing edge. With the processor clock at 3x the bus clock and rising edges aligned, the rule is as follows. On a stop, the pulses that begin at the capturing edge and one period later still appear, and none appear after them. On a release, the first pulse begins 2 periods after the capturing edge.
- R7: A captured change of the bus request takes effect within 1 bus clock period. On a stop, the pulse that begins at the capturing edge is the last one. On a release, the first pulse begins at the next rising edge.
- R8: `cpu_halted` and `pci_halted` are 1 exactly while their group is halted, and 0 while it runs.
- R9: `rst` is synchronous and active high. While it is held, both groups run and both flags read 0, whatever the stop inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | Processor source clock |
| clk_pci | input | 1 | Bus source clock to be gated |
| clk_pcif | input | 1 | Free-running bus clock used to capture the stop requests |
| rst | input | 1 | Synchronous active-high reset |
| cpu_stop_n | input | 1 | Active-low processor group stop request |
| pci_stop_n | input | 1 | Active-low bus group stop request |
| cpu_clk_o | output | N_CPU | Gated processor clocks |
| pci_clk_o | output | N_PCI | Gated bus clocks |
| cpu_halted | output | 1 | Processor group is halted |
| pci_halted | output | 1 | Bus group is halted |

## Verification
A gate enable that changes while its source clock is high shows up at once as a high pulse of the wrong width, in that same clock phase. A wrong capture or a wrong synchronizer depth shifts the number of rising edges counted in the window of one bus period after the capturing edge. The status flag then disagrees with the observed output within one period. A reset value that leaves a group halted is visible as a missing edge count while reset is still held.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    typedef enum logic {
        GRP_RUN  = 1'b0,
        GRP_HALT = 1'b1
    } grp_state_e;

    typedef struct packed {
        logic cpu_run;
        logic pci_run;
    } run_req_t;

    localparam run_req_t REQ_IDLE = '{cpu_run: 1'b1, pci_run: 1'b1};

    function automatic grp_state_e state_of(input logic run);
        return run ? GRP_RUN : GRP_HALT;
    endfunction

endpackage

// File: rtl/stop_sampler.sv
module stop_sampler
    import clkstop_pkg::*;
(
    input  logic     clk_ref,
    input  logic     rst,
    input  logic     cpu_stop_n,
    input  logic     pci_stop_n,
    output run_req_t req
);

    always_ff @(posedge clk_ref) begin
        if (rst) begin
            req <= REQ_IDLE;
        end else begin
            req <= '{cpu_run: cpu_stop_n, pci_run: pci_stop_n};
        end
    end

endmodule

// File: rtl/gate_enable.sv
module gate_enable #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run_in,
    output logic run_en
);

    logic run_pre;

    generate
        if (STAGES > 1) begin : g_sync
            localparam int RISE_STAGES = STAGES - 1;
            logic [RISE_STAGES-1:0] chain;

            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= '1;
                end else begin
                    chain[0] <= run_in;
                    for (int i = 1; i < RISE_STAGES; i++) begin
                        chain[i] <= chain[i-1];
                    end
                end
            end

            assign run_pre = chain[RISE_STAGES-1];
        end else begin : g_direct
            assign run_pre = run_in;
        end
    endgenerate

    // Final stage updates only while clk is low.
    always_ff @(negedge clk) begin
        if (rst) begin
            run_en <= 1'b1;
        end else begin
            run_en <= run_pre;
        end
    end

endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             en,
    output logic [WIDTH-1:0] gclk
);

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_gate
            assign gclk[g] = clk & en;
        end
    endgenerate

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int N_CPU    = 3,
    parameter int N_PCI    = 5,
    parameter int CPU_SYNC = 2
) (
    input  logic             clk_cpu,
    input  logic             clk_pci,
    input  logic             clk_pcif,
    input  logic             rst,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    output logic [N_CPU-1:0] cpu_clk_o,
    output logic [N_PCI-1:0] pci_clk_o,
    output logic             cpu_halted,
    output logic             pci_halted
);

    localparam int PCI_SYNC = 1;

    run_req_t req;
    logic     cpu_run_req;
    logic     cpu_en;
    logic     pci_en;

    stop_sampler u_sampler (
        .clk_ref    (clk_pcif),
        .rst        (rst),
        .cpu_stop_n (cpu_stop_n),
        .pci_stop_n (pci_stop_n),
        .req        (req)
    );

    assign cpu_run_req = req.cpu_run;

    gate_enable #(.STAGES(CPU_SYNC)) u_cpu_en (
        .clk    (clk_cpu),
        .rst    (rst),
        .run_in (cpu_run_req),
        .run_en (cpu_en)
    );

    gate_enable #(.STAGES(PCI_SYNC)) u_pci_en (
        .clk    (clk_pci),
        .rst    (rst),
        .run_in (req.pci_run),
        .run_en (pci_en)
    );

    clk_gate_bank #(.WIDTH(N_CPU)) u_cpu_gate (
        .clk  (clk_cpu),
        .en   (cpu_en),
        .gclk (cpu_clk_o)
    );

    clk_gate_bank #(.WIDTH(N_PCI)) u_pci_gate (
        .clk  (clk_pci),
        .en   (pci_en),
        .gclk (pci_clk_o)
    );

    assign cpu_halted = (state_of(cpu_en) == GRP_HALT);
    assign pci_halted = (state_of(pci_en) == GRP_HALT);

endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk #(
    parameter int N_CPU = 3,
    parameter int N_PCI = 5
) (
    input logic             clk_cpu,
    input logic             clk_pci,
    input logic             clk_pcif,
    input logic             rst,
    input logic             pci_stop_n,
    input logic             cpu_run_req,
    input logic [N_CPU-1:0] cpu_clk_o,
    input logic [N_PCI-1:0] pci_clk_o,
    input logic             cpu_halted,
    input logic             pci_halted
);

    logic       cpu_halt_at_rise;
    logic       pci_halt_at_rise;
    logic [1:0] pci_armed;
    logic [3:0] cpu_lag;

    always_ff @(posedge clk_cpu) cpu_halt_at_rise <= cpu_halted;
    always_ff @(posedge clk_pci) pci_halt_at_rise <= pci_halted;

    always_ff @(posedge clk_pcif) begin
        if (rst) pci_armed <= '0;
        else if (pci_armed != 2'd3) pci_armed <= pci_armed + 2'd1;
    end

    always_ff @(posedge clk_cpu) begin
        if (rst) cpu_lag <= '0;
        else if (cpu_halted == cpu_run_req) cpu_lag <= (cpu_lag == 4'hF) ? cpu_lag : cpu_lag + 4'd1;
        else cpu_lag <= '0;
    end

    // R4
    cpu_uniform_chk: assert property (@(negedge clk_cpu) disable iff (rst)
        (cpu_clk_o == '0) || (cpu_clk_o == '1));

    // R4
    pci_uniform_chk: assert property (@(negedge clk_pci) disable iff (rst)
        (pci_clk_o == '0) || (pci_clk_o == '1));

    // R4
    cpu_rest_low_chk: assert property (@(negedge clk_cpu) disable iff (rst)
        cpu_halted |-> (cpu_clk_o == '0));

    // R4
    pci_rest_low_chk: assert property (@(negedge clk_pci) disable iff (rst)
        pci_halted |-> (pci_clk_o == '0));

    // R5
    cpu_full_pulse_chk: assert property (@(negedge clk_cpu) disable iff (rst)
        cpu_halted == cpu_halt_at_rise);

    // R5
    pci_full_pulse_chk: assert property (@(negedge clk_pci) disable iff (rst)
        pci_halted == pci_halt_at_rise);

    // R7
    pci_latency_chk: assert property (@(posedge clk_pcif) disable iff (rst)
        (pci_armed == 2'd3) |-> (pci_halted == !$past(pci_stop_n)));

    // R6
    cpu_latency_chk: assert property (@(posedge clk_cpu) disable iff (rst)
        cpu_lag <= 4'd2);

endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(.N_CPU(N_CPU), .N_PCI(N_PCI)) u_chk (
    .clk_cpu     (clk_cpu),
    .clk_pci     (clk_pci),
    .clk_pcif    (clk_pcif),
    .rst         (rst),
    .pci_stop_n  (pci_stop_n),
    .cpu_run_req (cpu_run_req),
    .cpu_clk_o   (cpu_clk_o),
    .pci_clk_o   (pci_clk_o),
    .cpu_halted  (cpu_halted),
    .pci_halted  (pci_halted)
);

// File: tb/tb_clkstop_ctrl.sv
`timescale 1ns/1ps
module tb_clkstop_ctrl;

    localparam int N_CPU = 3;
    localparam int N_PCI = 5;

    // {cpu_stop_n, pci_stop_n, exp_cpu_halted, exp_pci_halted}
    localparam logic [3:0] VEC [0:5] = '{
        4'b1100, 4'b0110, 4'b0011, 4'b1001, 4'b0110, 4'b1100
    };

    logic clk_cpu = 1'b0;
    logic clk_pci = 1'b0;
    logic clk_pcif = 1'b0;
    logic rst = 1'b1;
    logic cpu_stop_n = 1'b1;
    logic pci_stop_n = 1'b1;
    logic [N_CPU-1:0] cpu_clk_o;
    logic [N_PCI-1:0] pci_clk_o;
    logic cpu_halted;
    logic pci_halted;

    int n_cmp = 0;
    int n_bad = 0;
    int cpu_rises = 0;
    int pci_rises = 0;
    int cpu_narrow = 0;
    int pci_narrow = 0;
    time cpu_t_rise = 0;
    time pci_t_rise = 0;
    logic prev_cpu_halt = 1'b0;
    logic prev_pci_halt = 1'b0;
    int w_cpu1, w_cpu2, w_pci1, w_pci2;

    always #5  clk_cpu  = ~clk_cpu;
    always #15 clk_pci  = ~clk_pci;
    always #15 clk_pcif = ~clk_pcif;

    clkstop_ctrl #(.N_CPU(N_CPU), .N_PCI(N_PCI)) dut (
        .clk_cpu    (clk_cpu),
        .clk_pci    (clk_pci),
        .clk_pcif   (clk_pcif),
        .rst        (rst),
        .cpu_stop_n (cpu_stop_n),
        .pci_stop_n (pci_stop_n),
        .cpu_clk_o  (cpu_clk_o),
        .pci_clk_o  (pci_clk_o),
        .cpu_halted (cpu_halted),
        .pci_halted (pci_halted)
    );

    always @(posedge cpu_clk_o[0]) begin
        cpu_rises++;
        cpu_t_rise = $time;
    end
    always @(negedge cpu_clk_o[0]) begin
        if (!rst && cpu_t_rise > 0 && ($time - cpu_t_rise) != 5) cpu_narrow++;
    end
    always @(posedge pci_clk_o[0]) begin
        pci_rises++;
        pci_t_rise = $time;
    end
    always @(negedge pci_clk_o[0]) begin
        if (!rst && pci_t_rise > 0 && ($time - pci_t_rise) != 15) pci_narrow++;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Two 30 ns windows starting 2 ns after a clk_pcif fall.
    task automatic measure();
        int c0, p0;
        c0 = cpu_rises; p0 = pci_rises;
        #30;
        w_cpu1 = cpu_rises - c0; w_pci1 = pci_rises - p0;
        c0 = cpu_rises; p0 = pci_rises;
        #30;
        w_cpu2 = cpu_rises - c0; w_pci2 = pci_rises - p0;
    endtask

    task automatic align();
        @(negedge clk_pcif);
        #2;
    endtask

    task automatic check_level(input logic exp_cpu_halt, input logic exp_pci_halt);
        @(posedge clk_cpu); #1;
        check("R4 cpu level while clock high", int'(cpu_clk_o), exp_cpu_halt ? 0 : (1 << N_CPU) - 1);
        @(posedge clk_pci); #1;
        check("R4 pci level while clock high", int'(pci_clk_o), exp_pci_halt ? 0 : (1 << N_PCI) - 1);
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R9: reset with both stop requests asserted
        cpu_stop_n = 1'b0;
        pci_stop_n = 1'b0;
        repeat (3) @(negedge clk_pcif);
        #2;
        measure();
        check("R9 cpu runs in reset", w_cpu2, 3);
        check("R9 pci runs in reset", w_pci2, 1);
        check("R9 cpu_halted in reset", int'(cpu_halted), 0);
        check("R9 pci_halted in reset", int'(pci_halted), 0);
        cpu_stop_n = 1'b1;
        pci_stop_n = 1'b1;
        align();
        rst = 1'b0;
        measure();
        check("R9 cpu after reset", w_cpu1 + w_cpu2, 6);
        check("R9 pci after reset", w_pci1 + w_pci2, 2);

        // Table walk: R2 R3 R6 R7 R8
        for (int i = 0; i < 6; i++) begin
            logic ec, ep;
            int xc1, xc2, xp1, xp2;
            ec = VEC[i][1];
            ep = VEC[i][0];
            xc1 = prev_cpu_halt ? 0 : 3;
            xc2 = ec ? 0 : 3;
            xp1 = prev_pci_halt ? 0 : 1;
            xp2 = ep ? 0 : 1;
            align();
            cpu_stop_n = VEC[i][3];
            pci_stop_n = VEC[i][2];
            measure();
            check($sformatf("R6 cpu edges first window v%0d", i), w_cpu1, xc1);
            check($sformatf("R6 cpu edges second window v%0d", i), w_cpu2, xc2);
            check($sformatf("R7 pci edges first window v%0d", i), w_pci1, xp1);
            check($sformatf("R7 pci edges second window v%0d", i), w_pci2, xp2);
            align();
            measure();
            check($sformatf("R2 cpu steady edges v%0d", i), w_cpu1 + w_cpu2, ec ? 0 : 6);
            check($sformatf("R3 pci steady edges v%0d", i), w_pci1 + w_pci2, ep ? 0 : 2);
            check($sformatf("R8 cpu_halted v%0d", i), int'(cpu_halted), int'(ec));
            check($sformatf("R8 pci_halted v%0d", i), int'(pci_halted), int'(ep));
            check_level(ec, ep);
            prev_cpu_halt = ec;
            prev_pci_halt = ep;
        end

        // R1: short low pulses between capturing edges are ignored
        align();
        cpu_stop_n = 1'b0;
        pci_stop_n = 1'b0;
        #10;
        cpu_stop_n = 1'b1;
        pci_stop_n = 1'b1;
        #1;
        measure();
        check("R1 cpu ignores short pulse", w_cpu1 + w_cpu2, 6);
        check("R1 pci ignores short pulse", w_pci1 + w_pci2, 2);
        check("R1 cpu_halted unchanged", int'(cpu_halted), 0);
        check("R1 pci_halted unchanged", int'(pci_halted), 0);

        // R5: no shortened pulse over the whole run
        check("R5 cpu narrow pulses", cpu_narrow, 0);
        check("R5 pci narrow pulses", pci_narrow, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule